// File: doc/BRIEF.md
# Triggered IQ Sample Buffer Controller

This block moves baseband IQ samples between the converter streams and two local block RAMs. A single trigger pulse starts a transmit sequencer and a receive sequencer together. The transmit side reads a waveform out of its RAM and presents it to the DAC. The receive side writes one sample per cycle into its RAM. Each side has its own programmed length. When a side reaches its length, it stops and holds a sticky done flag.

Each RAM is used as two alternating halves. Whenever the last address of a half has been accessed, the block pulses an interrupt together with a flag that names the half. A processor can then empty that half into external memory, or refill it with the next part of the waveform, while the other half is in use.

The receive data can come from one of three sources: the ADC, a free-running counter, or the block's own DAC stream looped back. The block does not delay the write address to hide any pipeline latency. Latency therefore shows up as leading samples at the start of the receive buffer.

Top module: `trig_iq_buffer`

## Requirements
- R1: After reset the DAC output is zero, no RAM write or read is issued, and both done flags and all interrupt outputs are low.
- R2: A trigger pulse seen on a clock edge starts both sequencers. In the next cycle the receive side writes address 0 and the transmit side reads address 0.
- R3: The receive side writes exactly rx_len samples, one per cycle, to consecutive addresses modulo the RAM depth. It then raises rx_done_o.
- R4: The transmit side issues exactly tx_len reads at consecutive addresses. The word read at address a appears on dac_data_o in the cycle after that read. In every other cycle dac_data_o is zero, including while the side is idle or done.
- R5: In the cycle after the receive side writes the last address of a RAM half, rx_irq_o pulses for one cycle. rx_irq_half_o is 0 for the lower half and 1 for the upper half.
- R6: The transmit side has the same half-boundary interrupt on tx_irq_o and tx_irq_half_o, based on its reads.
- R7: With mode 0 (ADC), the written word equals adc_data_i in the cycle of the write. A sample carries I in bits 31:16 and Q in bits 15:0.
- R8: With mode 1 (counter), each successive receive write carries a value one greater than the write before it.
- R9: With mode 2 (loopback), the written word equals the DAC output of the same cycle. The receive buffer therefore holds 0 at index 0 and the transmit word k at index k+1 for each k below tx_len, with zeros after the waveform.
- R10: A done flag stays set until its clear input is pulsed. Triggers that arrive while a side is done start no accesses on that side. After a clear, the side is idle and can be triggered again.
- R11: The two lengths are independent. With rx_len above tx_len, the receive side keeps writing after the transmit side has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trigger_i | input | 1 | Single-cycle start pulse for both sides |
| mode_i | input | 2 | Receive source: 0 ADC, 1 counter, 2 loopback, 3 ADC |
| tx_len_i | input | LEN_W | Transmit sample count |
| rx_len_i | input | LEN_W | Receive sample count |
| tx_done_clr_i | input | 1 | Clears the transmit done flag |
| rx_done_clr_i | input | 1 | Clears the receive done flag |
| adc_data_i | input | 32 | ADC sample, I in upper half, Q in lower half |
| dac_data_o | output | 32 | DAC sample |
| txram_rd_o | output | 1 | Transmit RAM read strobe |
| txram_addr_o | output | log2(DEPTH) | Transmit RAM address |
| txram_rdata_i | input | 32 | Transmit RAM data, one cycle after the address |
| rxram_we_o | output | 1 | Receive RAM write enable |
| rxram_addr_o | output | log2(DEPTH) | Receive RAM address |
| rxram_wdata_o | output | 32 | Receive RAM write data |
| tx_irq_o | output | 1 | Transmit half-boundary interrupt pulse |
| tx_irq_half_o | output | 1 | Half just read out by the transmit side |
| rx_irq_o | output | 1 | Receive half-boundary interrupt pulse |
| rx_irq_half_o | output | 1 | Half just filled by the receive side |
| tx_done_o | output | 1 | Sticky transmit done flag |
| rx_done_o | output | 1 | Sticky receive done flag |

## Verification
Some properties are checked by assertions on every cycle:
- consecutive accesses step the address by one;
- a triggered start lands on address 0;
- an interrupt follows only the last address of a half;
- done flags stay set until cleared;
- the DAC stays at zero once transmission is done;
- counter-mode writes increase by one.

Other behaviour can only be shown by the bench scenarios: the exact data in each mode, the leading zero sample in loopback, the total access counts per length, and the fact that triggers are ignored while done. The bench checks these against a RAM model and a queue of expected writes.

// File: rtl/iqbuf_pkg.sv
package iqbuf_pkg;
    localparam int SAMPLE_W = 32;
    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_ADC   = 2'd0,
        SRC_COUNT = 2'd1,
        SRC_LOOP  = 2'd2
    } src_sel_e;
endpackage

// File: rtl/iqbuf_seq.sv
// Sequencer for one direction: counts accesses, wraps the address,
// pulses an interrupt at the end of each RAM half, and holds done.
module iqbuf_seq
    import iqbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 12,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int HALF_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              clr_i,
    output logic              act_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              irq_o,
    output logic              irq_half_o,
    output logic              done_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic             irq;
        logic             half;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        case (s_q.st)
            SEQ_IDLE: begin
                if (trig_i) begin
                    s_d.cnt = '0;
                    s_d.st  = (len_i == '0) ? SEQ_DONE : SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (&s_q.cnt[HALF_W-1:0]) begin
                    s_d.irq  = 1'b1;
                    s_d.half = s_q.cnt[HALF_W];
                end
                if (s_q.cnt == len_i - 1'b1) s_d.st  = SEQ_DONE;
                else                         s_d.cnt = s_q.cnt + 1'b1;
            end
            SEQ_DONE: begin
                if (clr_i) s_d.st = SEQ_IDLE;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, cnt: '0, irq: 1'b0, half: 1'b0};
        else        s_q <= s_d;
    end

    logic idle_q;
    assign idle_q     = (s_q.st == SEQ_IDLE);
    assign act_o      = (s_q.st == SEQ_RUN);
    assign addr_o     = s_q.cnt[ADDR_W-1:0];
    assign irq_o      = s_q.irq;
    assign irq_half_o = s_q.half;
    assign done_o     = (s_q.st == SEQ_DONE);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_o && $past(act_o) |-> addr_o == ADDR_W'($past(addr_o) + 1'b1));
    // R2
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trig_i) && $past(idle_q) && ($past(len_i) != '0) |-> act_o && addr_o == '0);
    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(act_o) && (&$past(addr_o[HALF_W-1:0])));
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clr_i |=> done_o);
endmodule

// File: rtl/iqbuf_src.sv
// Receive source selection.
module iqbuf_src
    import iqbuf_pkg::*;
(
    input  logic [1:0] mode_i,
    input  sample_t    adc_i,
    input  sample_t    count_i,
    input  sample_t    loop_i,
    output sample_t    sample_o
);
    always_comb begin
        case (mode_i)
            SRC_COUNT: sample_o = count_i;
            SRC_LOOP:  sample_o = loop_i;
            default:   sample_o = adc_i;
        endcase
    end
endmodule

// File: rtl/trig_iq_buffer.sv
module trig_iq_buffer
    import iqbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 12,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger_i,
    input  logic [1:0]        mode_i,
    input  logic [LEN_W-1:0]  tx_len_i,
    input  logic [LEN_W-1:0]  rx_len_i,
    input  logic              tx_done_clr_i,
    input  logic              rx_done_clr_i,
    input  logic [31:0]       adc_data_i,
    output logic [31:0]       dac_data_o,
    output logic              txram_rd_o,
    output logic [ADDR_W-1:0] txram_addr_o,
    input  logic [31:0]       txram_rdata_i,
    output logic              rxram_we_o,
    output logic [ADDR_W-1:0] rxram_addr_o,
    output logic [31:0]       rxram_wdata_o,
    output logic              tx_irq_o,
    output logic              tx_irq_half_o,
    output logic              rx_irq_o,
    output logic              rx_irq_half_o,
    output logic              tx_done_o,
    output logic              rx_done_o
);
    typedef struct packed {
        sample_t ctr;
        logic    tx_vld;
    } top_t;

    top_t t_d, t_q;

    iqbuf_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trigger_i), .len_i(tx_len_i),
        .clr_i(tx_done_clr_i), .act_o(txram_rd_o), .addr_o(txram_addr_o),
        .irq_o(tx_irq_o), .irq_half_o(tx_irq_half_o), .done_o(tx_done_o)
    );

    iqbuf_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rx_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trigger_i), .len_i(rx_len_i),
        .clr_i(rx_done_clr_i), .act_o(rxram_we_o), .addr_o(rxram_addr_o),
        .irq_o(rx_irq_o), .irq_half_o(rx_irq_half_o), .done_o(rx_done_o)
    );

    always_comb begin
        t_d        = t_q;
        t_d.ctr    = t_q.ctr + 1'b1;
        t_d.tx_vld = txram_rd_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{ctr: '0, tx_vld: 1'b0};
        else        t_q <= t_d;
    end

    assign dac_data_o = t_q.tx_vld ? txram_rdata_i : '0;

    iqbuf_src u_src (
        .mode_i(mode_i), .adc_i(adc_data_i), .count_i(t_q.ctr),
        .loop_i(dac_data_o), .sample_o(rxram_wdata_o)
    );

    // R4
    dac_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o && $past(tx_done_o) |-> dac_data_o == '0);
    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxram_we_o && $past(rxram_we_o) && mode_i == SRC_COUNT && $past(mode_i) == SRC_COUNT
        |-> rxram_wdata_o == $past(rxram_wdata_o) + 1'b1);
endmodule

// File: tb/trig_iq_buffer_test.sv
`timescale 1ns/1ps
module trig_iq_buffer_test;
    localparam int DEPTH = 16;
    localparam int LEN_W = 12;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trigger_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [LEN_W-1:0] tx_len_i = '0, rx_len_i = '0;
    logic tx_done_clr_i = 1'b0, rx_done_clr_i = 1'b0;
    logic [31:0] adc_data_i = '0;
    logic [31:0] dac_data_o, txram_rdata_i, rxram_wdata_o;
    logic txram_rd_o, rxram_we_o;
    logic [AW-1:0] txram_addr_o, rxram_addr_o;
    logic tx_irq_o, tx_irq_half_o, rx_irq_o, rx_irq_half_o, tx_done_o, rx_done_o;

    always #2 clk = ~clk;

    trig_iq_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (.*);

    logic [31:0] tmem [DEPTH];
    always @(posedge clk) txram_rdata_i <= tmem[txram_addr_o];

    int checks = 0, errors = 0;
    typedef struct { int addr; logic [31:0] data; } exp_t;
    exp_t q[$];
    string tag = "R7";
    bit mon_on = 0, cnt_mode = 0, have_prev = 0;
    logic [31:0] prev_cnt;
    int wr_cnt = 0, tx_reads = 0;
    bit prev_we = 0, prev_rd = 0;
    logic [AW-1:0] prev_waddr, prev_raddr;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int k);
        return {16'(k * 5 + 2), 16'(16'hF000 - k)};
    endfunction

    // monitor: pops the scoreboard and models RAM read timing
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (rxram_we_o) begin
                wr_cnt++;
                if (cnt_mode) begin
                    if (have_prev) chk("R8", rxram_wdata_o, prev_cnt + 1);
                    prev_cnt  = rxram_wdata_o;
                    have_prev = 1;
                end else if (q.size() == 0) begin
                    chk("R10 unexpected write", 32'(rxram_addr_o), 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({tag, " addr R3"}, 32'(rxram_addr_o), 32'(e.addr));
                    chk({tag, " data"}, rxram_wdata_o, e.data);
                end
            end
            if (prev_we && prev_waddr[2:0] == 3'd7)
                chk("R5 irq/half", {30'd0, rx_irq_o, rx_irq_half_o}, {30'd0, 1'b1, prev_waddr[3]});
            else if (rx_irq_o) chk("R5 spurious irq", 32'(rx_irq_o), 32'd0);
            if (prev_rd) chk("R4 dac", dac_data_o, tmem[prev_raddr]);
            else if (dac_data_o != '0) chk("R4 dac idle", dac_data_o, 32'd0);
            if (prev_rd && prev_raddr[2:0] == 3'd7)
                chk("R6 irq/half", {30'd0, tx_irq_o, tx_irq_half_o}, {30'd0, 1'b1, prev_raddr[3]});
            else if (tx_irq_o) chk("R6 spurious irq", 32'(tx_irq_o), 32'd0);
            if (txram_rd_o) tx_reads++;
            prev_we = rxram_we_o; prev_waddr = rxram_addr_o;
            prev_rd = txram_rd_o; prev_raddr = txram_addr_o;
        end
    end

    // driver: kind 0 ADC, 1 counter, 2 loopback
    task automatic run_capture(int rxl, int txl, int kind, string t);
        int w0, r0;
        w0 = wr_cnt; r0 = tx_reads;
        tag = t; cnt_mode = (kind == 1); have_prev = 0;
        @(posedge clk); #1;
        mode_i = 2'(kind); rx_len_i = LEN_W'(rxl); tx_len_i = LEN_W'(txl);
        trigger_i = 1'b1;
        @(posedge clk); #1;
        trigger_i = 1'b0;
        for (int k = 0; k < rxl; k++) begin
            exp_t e;
            adc_data_i = pat(k);
            e.addr = k % DEPTH;
            if (kind == 0)                  e.data = pat(k);
            else if (k >= 1 && k <= txl)    e.data = tmem[k-1];
            else                            e.data = 32'd0;
            if (kind != 1) q.push_back(e);
            if (k == 0) begin
                @(negedge clk);
                // R2
                chk("R2 start", {28'd0, txram_rd_o, rxram_we_o, 2'(txram_addr_o + rxram_addr_o)}, 32'hC);
            end
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk("R3 rx_done", 32'(rx_done_o), 32'd1);
        chk("R11 tx finished first", 32'(tx_done_o), 32'd1);
        chk("R3 write count", 32'(wr_cnt - w0), 32'(rxl));
        chk("R4 read count", 32'(tx_reads - r0), 32'(txl));
    endtask

    task automatic clear_both();
        @(posedge clk); #1;
        tx_done_clr_i = 1; rx_done_clr_i = 1;
        @(posedge clk); #1;
        tx_done_clr_i = 0; rx_done_clr_i = 0;
        @(negedge clk);
        chk("R10 cleared", {30'd0, tx_done_o, rx_done_o}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) tmem[i] = {16'(i * 3 + 1), 16'(-i)};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 dac", dac_data_o, 32'd0);
        chk("R1 strobes", {28'd0, rxram_we_o, txram_rd_o, tx_irq_o, rx_irq_o}, 32'd0);
        chk("R1 done", {30'd0, tx_done_o, rx_done_o}, 32'd0);
        mon_on = 1;

        // R7 R11: ADC source, rx longer than tx, address wraps
        run_capture(20, 10, 0, "R7");

        // R10: trigger while done is ignored
        begin
            int w0, r0;
            w0 = wr_cnt; r0 = tx_reads;
            @(posedge clk); #1 trigger_i = 1;
            @(posedge clk); #1 trigger_i = 0;
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk("R10 no writes", 32'(wr_cnt - w0), 32'd0);
            chk("R10 no reads", 32'(tx_reads - r0), 32'd0);
            chk("R10 still done", {30'd0, tx_done_o, rx_done_o}, 32'd3);
        end
        clear_both();

        // R9: loopback with leading pad sample
        run_capture(16, 12, 2, "R9");
        clear_both();

        // R8: counter source
        run_capture(9, 3, 1, "R8");
        clear_both();

        repeat (3) @(posedge clk);
        chk("R3 scoreboard drained", 32'(q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule